// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block produces the raster timing for a parallel LCD panel: horizontal sync, vertical sync and a data-enable strobe, plus the live pixel and line positions and a one-cycle marker at the top of each frame. A pixel counter runs on every clock while the block is running. A line counter steps each time the pixel counter wraps. Every sync and active edge is compared against a start/end pair that software writes, so porch and sync widths are not fixed in the hardware. The same counters serve both TFT-style layouts and panels whose windows fall anywhere in the line.

Software writes the horizontal and vertical totals and the four window pairs while the block is stopped, then sets the enable bit. A disable request does not cut the frame short. The current frame runs to its last pixel, the counters park at zero, and a done flag is raised. A dual-scan mode halves the number of lines in each frame, so that each half of a split panel gets half of the programmed line count.

Top module: `lcd_sync_gen`

## Requirements
- R1: After reset the block is stopped: `running`, `stop_done`, `hsync`, `vsync`, `de` and `frame_start` are low, and both counters read 0.
- R2: Address 1 holds the horizontal total in bits [2*CW-1:CW] and the vertical total in bits [CW-1:0]. While running, `pix_cnt` steps by one each clock and returns to 0 on the cycle after it reaches horizontal total minus one.
- R3: `line_cnt` steps by one on each pixel wrap and returns to 0 after it reaches the frame line count minus one. `frame_start` is high exactly when the block is running and both counters are 0.
- R4: A window register holds its start in bits [2*CW-1:CW] and its end in bits [CW-1:0]. A window is active when start <= counter < end. `hsync` follows the window at address 2 against `pix_cnt`, and `vsync` follows the window at address 3 against `line_cnt`.
- R5: `de` is high when `pix_cnt` lies in the horizontal active window (address 4) and `line_cnt` lies in the vertical active window (address 5).
- R6: A window whose start equals its end, or whose start exceeds its end, never asserts its output.
- R7: Writing address 0 with bit 3 set starts a stopped block at pixel 0, line 0, with `frame_start` high in the first cycle, and clears `stop_done`. The same write to a running block leaves the counters undisturbed.
- R8: Writing address 0 with bit 4 set and bit 3 clear while running lets the frame finish. After the last pixel of the last line the block stops, the counters read 0, all timing outputs are low and `stop_done` stays high until the next enable.
- R9: An enable write clears any pending disable request, and a write with both bits 3 and 4 set acts as an enable only.
- R10: Address 6 bit 0 selects dual-scan. The frame then has floor(vertical total / 2) lines, and vertical windows are compared against that shorter line count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 2*CW | Register write data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_cnt | output | CW | Current pixel position in the line |
| line_cnt | output | CW | Current line position in the frame |
| frame_start | output | 1 | High on the first pixel of each frame |
| running | output | 1 | Block is producing timing |
| stop_done | output | 1 | Graceful stop has completed |

## Verification
The bench issues a disable request on a cycle in the middle of the frame and checks that timing continues to the true last pixel. A design that stopped at once, or one that stopped at the next line wrap, would drop `running` early. It checks that an enable given after a disable request cancels it, and that a write with both control bits set counts as an enable. A design that let the request win would halt at the frame boundary. It programs windows with equal and with reversed edges, which a design with an inclusive end comparison would show as a one-cycle pulse. It runs dual-scan with an odd line total, where a design that rounded the half upward would insert an extra line before `frame_start`.

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen #(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_addr,
  input  logic [2*CW-1:0] cfg_wdata,
  output logic            hsync,
  output logic            vsync,
  output logic            de,
  output logic [CW-1:0]   pix_cnt,
  output logic [CW-1:0]   line_cnt,
  output logic            frame_start,
  output logic            running,
  output logic            stop_done
);
  localparam int DW = 2 * CW;
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_TOT  = 3'd1;
  localparam logic [2:0] A_HS   = 3'd2;
  localparam logic [2:0] A_VS   = 3'd3;
  localparam logic [2:0] A_HA   = 3'd4;
  localparam logic [2:0] A_VA   = 3'd5;
  localparam logic [2:0] A_MODE = 3'd6;
  localparam int EN_BIT  = 3;
  localparam int DIS_BIT = 4;

  logic [DW-1:0] tot_r, hs_r, vs_r, ha_r, va_r;
  logic          dual_r, stop_pend;
  logic [CW-1:0] h_total, v_total, v_eff;
  logic          h_wrap, v_wrap, frame_end;
  logic          en_wr, dis_wr;

  assign h_total = tot_r[DW-1:CW];
  assign v_total = tot_r[CW-1:0];
  assign v_eff   = dual_r ? (v_total >> 1) : v_total;

  assign h_wrap    = ({1'b0, pix_cnt} + 1'b1) >= {1'b0, h_total};
  assign v_wrap    = ({1'b0, line_cnt} + 1'b1) >= {1'b0, v_eff};
  assign frame_end = h_wrap && v_wrap;

  assign en_wr  = cfg_we && (cfg_addr == A_CTRL) && cfg_wdata[EN_BIT];
  assign dis_wr = cfg_we && (cfg_addr == A_CTRL) && cfg_wdata[DIS_BIT] && !cfg_wdata[EN_BIT];

  function automatic logic in_win(input logic [CW-1:0] c, input logic [DW-1:0] w);
    return (c >= w[DW-1:CW]) && (c < w[CW-1:0]);
  endfunction

  assign hsync       = running && in_win(pix_cnt, hs_r);
  assign vsync       = running && in_win(line_cnt, vs_r);
  assign de          = running && in_win(pix_cnt, ha_r) && in_win(line_cnt, va_r);
  assign frame_start = running && (pix_cnt == '0) && (line_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_r  <= '0;
      hs_r   <= '0;
      vs_r   <= '0;
      ha_r   <= '0;
      va_r   <= '0;
      dual_r <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_TOT:  tot_r  <= cfg_wdata;
        A_HS:   hs_r   <= cfg_wdata;
        A_VS:   vs_r   <= cfg_wdata;
        A_HA:   ha_r   <= cfg_wdata;
        A_VA:   va_r   <= cfg_wdata;
        A_MODE: dual_r <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_cnt   <= '0;
      line_cnt  <= '0;
      running   <= 1'b0;
      stop_pend <= 1'b0;
      stop_done <= 1'b0;
    end else begin
      if (running) begin
        if (frame_end && stop_pend) begin
          running   <= 1'b0;
          stop_pend <= 1'b0;
          stop_done <= 1'b1;
          pix_cnt   <= '0;
          line_cnt  <= '0;
        end else if (h_wrap) begin
          pix_cnt  <= '0;
          line_cnt <= v_wrap ? '0 : line_cnt + 1'b1;
        end else begin
          pix_cnt <= pix_cnt + 1'b1;
        end
      end
      if (en_wr) begin
        running   <= 1'b1;
        stop_pend <= 1'b0;
        stop_done <= 1'b0;
      end else if (dis_wr && running) begin
        stop_pend <= 1'b1;
      end
    end
  end
endmodule

module lcd_sync_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] ht,
  input logic [2*CW-1:0] hs_w,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic [CW-1:0] pix_cnt,
  input logic [CW-1:0] line_cnt,
  input logic          frame_start,
  input logic          running,
  input logic          stop_done
);
  logic mid_line;
  assign mid_line = running && (({1'b0, pix_cnt} + 1'b1) < {1'b0, ht});

  assert_pix_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mid_line |=> pix_cnt == $past(pix_cnt) + 1'b1);

  assert_line_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mid_line |=> $stable(line_cnt));

  assert_zero_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_w[2*CW-1:CW] >= hs_w[CW-1:0]) |-> !hsync);

  assert_start_marker_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> frame_start && pix_cnt == '0);

  assert_stopped_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (pix_cnt == '0 && line_cnt == '0 && !hsync && !vsync && !de && !frame_start));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |-> !running);
endmodule

bind lcd_sync_gen lcd_sync_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ht(h_total), .hs_w(hs_r),
  .hsync(hsync), .vsync(vsync), .de(de), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
  .frame_start(frame_start), .running(running), .stop_done(stop_done)
);

// File: tb/tb_lcd_sync_gen.sv
module tb_lcd_sync_gen;
  localparam int CW = 16;
  localparam int CLK_PERIOD = 10;
  localparam int NEVER = 1 << 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [2*CW-1:0] cfg_wdata = '0;
  logic hsync, vsync, de, frame_start, running, stop_done;
  logic [CW-1:0] pix_cnt, line_cnt;

  int checks = 0, errors = 0;
  int ht, vt, dual, hs_s, hs_e, vs_s, vs_e, ha_s, ha_e, va_s, va_e;
  int stop_n;
  int hs_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_sync_gen #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
    .frame_start(frame_start), .running(running), .stop_done(stop_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit inw(input int c, input int s, input int e);
    return c >= s && c < e;
  endfunction

  task automatic tick();
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setw(input int a, input int d);
    cfg_we = 1'b1;
    cfg_addr = a[2:0];
    cfg_wdata = d;
  endtask

  task automatic cfgw(input int a, input int d);
    setw(a, d);
    tick();
  endtask

  task automatic check_cycle(input int n);
    bit run;
    int vte, ep, el;
    run = n < stop_n;
    vte = dual ? vt / 2 : vt;
    ep = run ? n % ht : 0;
    el = run ? (n / ht) % vte : 0;
    chk(pix_cnt == ep, "R2 pix_cnt", pix_cnt, ep);
    chk(line_cnt == el, "R3 line_cnt", line_cnt, el);
    chk(frame_start == (run && ep == 0 && el == 0), "R3 frame_start", frame_start, run && ep == 0 && el == 0);
    chk(hsync == (run && inw(ep, hs_s, hs_e)), "R4 hsync", hsync, run && inw(ep, hs_s, hs_e));
    chk(vsync == (run && inw(el, vs_s, vs_e)), "R4 vsync", vsync, run && inw(el, vs_s, vs_e));
    chk(de == (run && inw(ep, ha_s, ha_e) && inw(el, va_s, va_e)), "R5 de", de,
        run && inw(ep, ha_s, ha_e) && inw(el, va_s, va_e));
    chk(running == run, "R8 running", running, run);
    chk(stop_done == !run, "R8 stop_done", stop_done, !run);
    if (hsync) hs_seen++;
  endtask

  task automatic load_cfg();
    cfgw(1, (ht << 16) | vt);
    cfgw(2, (hs_s << 16) | hs_e);
    cfgw(3, (vs_s << 16) | vs_e);
    cfgw(4, (ha_s << 16) | ha_e);
    cfgw(5, (va_s << 16) | va_e);
    cfgw(6, dual);
  endtask

  // Runs cycles 0..last after an enable; optional control writes at n1 and n2.
  task automatic run_frames(input int last, input int n1, input int d1, input int n2, input int d2);
    for (int n = 0; n <= last; n++) begin
      check_cycle(n);
      if (n == n1) setw(0, d1);
      if (n == n2) setw(0, d2);
      tick();
    end
  endtask

  task automatic go();
    setw(0, 1 << 3);
    tick();
  endtask

  function automatic int stop_at(input int nw, input int f);
    return ((nw + 2 + f - 1) / f) * f;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7319));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!running && !stop_done, "R1 run/done", {running, stop_done}, 0);
    chk(!hsync && !vsync && !de && !frame_start, "R1 timing", {hsync, vsync, de, frame_start}, 0);
    chk(pix_cnt == 0 && line_cnt == 0, "R1 counters", pix_cnt + line_cnt, 0);

    // Directed: R8 graceful stop mid-frame
    ht = 10; vt = 6; dual = 0;
    hs_s = 0; hs_e = 2; vs_s = 0; vs_e = 1; ha_s = 3; ha_e = 8; va_s = 2; va_e = 5;
    load_cfg();
    stop_n = stop_at(25, 60);
    go();
    run_frames(70, 25, 1 << 4, -1, 0);

    // R7 re-enable from stopped clears done; R9 enable cancels disable, both bits act as enable
    stop_n = NEVER;
    go();
    run_frames(200, 5, 1 << 4, 12, 1 << 3);
    chk(running == 1, "R9 still running", running, 1);
    // R7 enable while running keeps counting (continue index at 201)
    stop_n = stop_at(201 + 3, 60);
    for (int n = 201; n <= 260; n++) begin
      check_cycle(n);
      if (n == 201) setw(0, (1 << 3) | (1 << 4));
      if (n == 203) setw(0, 1 << 4);
      tick();
    end

    // R6 zero-width and reversed windows
    hs_s = 4; hs_e = 4; vs_s = 3; vs_e = 1;
    load_cfg();
    hs_seen = 0;
    stop_n = stop_at(61, 60);
    go();
    run_frames(125, 61, 1 << 4, -1, 0);
    chk(hs_seen == 0, "R6 hsync never high", hs_seen, 0);

    // R10 dual-scan, odd vertical total: 7 -> 3 lines
    ht = 8; vt = 7; dual = 1;
    hs_s = 1; hs_e = 3; vs_s = 1; vs_e = 2; ha_s = 2; ha_e = 7; va_s = 0; va_e = 3;
    load_cfg();
    stop_n = stop_at(30, 24);
    go();
    run_frames(75, 30, 1 << 4, -1, 0);
    chk(stop_n == 48, "R10 frame length", stop_n, 48);

    // Random configurations
    for (int r = 0; r < 25; r++) begin
      int nw, f;
      ht = 4 + $urandom % 17;
      vt = 2 + $urandom % 9;
      dual = (vt >= 4) ? $urandom % 2 : 0;
      hs_s = $urandom % (ht + 1); hs_e = $urandom % (ht + 1);
      ha_s = $urandom % (ht + 1); ha_e = $urandom % (ht + 1);
      vs_s = $urandom % (vt + 1); vs_e = $urandom % (vt + 1);
      va_s = $urandom % (vt + 1); va_e = $urandom % (vt + 1);
      load_cfg();
      f = ht * (dual ? vt / 2 : vt);
      nw = $urandom % (2 * f);
      stop_n = stop_at(nw, f);
      go();
      run_frames(stop_n + 4, nw, 1 << 4, -1, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule